// File: doc/BRIEF.md
# CSR Address Access Checker

This block decides, from the address of a control/status register access alone, whether the access must raise an illegal-instruction exception. It looks at the 12-bit register address, the hart's current privilege level, a debug-mode flag and a write-intent bit. Address bits [11:10] equal to 2'b11 mark a register as read-only. Address bits [9:8] give the lowest privilege level allowed to touch it. A lookup into a parameterized table of implemented addresses rejects every address that is not present. A 16-entry window at 0x7B0–0x7BF is usable only in debug mode, so even machine mode traps there. The neighbouring trigger window at 0x7A0–0x7AF stays open to machine mode.

The decision path is purely combinational and is meant to sit in the decode stage of a pipeline. The block also holds a single cycle counter. It can be read at a user-level read-only address and read or written at a machine-level read/write address. Both addresses reach the same storage, so the two access rules can be seen side by side. A write attempt that the checker rejects never reaches the counter.

Top module: `csr_gate`

## Requirements
- R1: An address that is absent from the implemented table drives `hit` low and `illegal` high, whatever the privilege level.
- R2: An access whose effective privilege is numerically below address bits [9:8] raises `illegal`. Privilege is encoded as U=2'b00, S=2'b01, H=2'b10, M=2'b11. For example, an S-level write to 0x300 traps.
- R3: When address bits [11:10]=2'b11 and `wr_intent` is high, both `ro_violation` and `illegal` go high. A read without write intent to the same register does not trap.
- R4: Outside debug mode, any access to 0x7B0–0x7BF raises `illegal`, even at M level. In debug mode the same addresses are legal.
- R5: Implemented addresses in 0x7A0–0x7AF are legal for M level outside debug mode, for both reads and writes.
- R6: While `debug_mode` is high, the privilege comparison treats the hart as M level, whatever `priv_mode` is.
- R7: An implemented address with enough privilege and no read-only write and no debug-window block gives `illegal`=0 and `ro_violation`=0.
- R8: A synchronous active-high `rst` clears the counter to zero. Otherwise the counter grows by one on every rising clock edge.
- R9: Legal reads at 0xC00 and at 0xB00 return the same counter value on `rd_data`.
- R10: A write with `acc_valid`, `wr_intent`, address 0xB00 and no `illegal` loads `wr_data` into the counter at the next edge, replacing that edge's increment.
- R11: A write attempt that is flagged `illegal` (to 0xC00, or to 0xB00 from below M level) leaves the counter counting by one.
- R12: `rd_data` is zero unless the access is a legal read of 0xC00 or 0xB00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter |
| rst | input | 1 | Synchronous active-high reset of the counter |
| csr_addr | input | 12 | Register address being accessed |
| priv_mode | input | 2 | Current privilege level (U=0, S=1, H=2, M=3) |
| debug_mode | input | 1 | Hart is in debug mode |
| wr_intent | input | 1 | The instruction would write the register |
| acc_valid | input | 1 | An access is being performed this cycle |
| wr_data | input | 32 | Value to load into the counter on a legal write |
| illegal | output | 1 | Access must raise illegal-instruction |
| ro_violation | output | 1 | Write intent toward a read-only address |
| hit | output | 1 | Address is in the implemented table |
| rd_data | output | 32 | Counter value on a legal counter read, else zero |

## Verification
A legal write to the machine-level counter address and the counter's own increment both act on the same clock edge. The bench presents a committed write and checks that the loaded value, not the incremented one, is visible after that edge. It then checks that counting resumes from the loaded value on the following edge. A second overlap is checked where read-only and privilege failures hit the same access, such as a U-level write to 0xF11. For that access both `ro_violation` and `illegal` must be high.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_H = 2'b10,
    PRIV_M = 2'b11
  } priv_t;

  localparam logic [11:0] CNT_URO_ADDR = 12'hC00;
  localparam logic [11:0] CNT_MRW_ADDR = 12'hB00;
  localparam logic [11:0] DBG_WIN_BASE = 12'h7B0;
  localparam logic [11:0] TRG_WIN_BASE = 12'h7A0;
  localparam int unsigned WIN_LSB_BITS = 4;

endpackage

// File: rtl/csr_impl_lookup.sv
module csr_impl_lookup #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned IMPL_N = 14,
  parameter logic [ADDR_W-1:0] IMPL_TABLE [IMPL_N] = '{
    12'hC00, 12'hB00, 12'h300, 12'h305, 12'h341, 12'hF11, 12'h100,
    12'h105, 12'h140, 12'h7A0, 12'h7A1, 12'h7B0, 12'h7B1, 12'h800
  }
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic [IMPL_N-1:0] match_vec;

  genvar gi;
  generate
    for (gi = 0; gi < IMPL_N; gi++) begin : g_entry
      assign match_vec[gi] = (addr == IMPL_TABLE[gi]);
    end
  endgenerate

  assign hit = |match_vec;

endmodule

// File: rtl/csr_rights_eval.sv
module csr_rights_eval
  import csr_chk_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        priv,
  input  logic              debug,
  input  logic              wr_intent,
  input  logic              hit,
  output logic              illegal,
  output logic              ro_violation
);

  localparam int unsigned RO_MSB   = ADDR_W - 1;
  localparam int unsigned RO_LSB   = ADDR_W - 2;
  localparam int unsigned PRV_MSB  = ADDR_W - 3;
  localparam int unsigned PRV_LSB  = ADDR_W - 4;
  localparam int unsigned WIN_TOPW = ADDR_W - WIN_LSB_BITS;

  logic [1:0] eff_priv;
  logic       priv_low;
  logic       dbg_block;
  logic       ro_addr;

  always_comb begin
    eff_priv  = debug ? PRIV_M : priv;
    priv_low  = (eff_priv < addr[PRV_MSB:PRV_LSB]);
    ro_addr   = (addr[RO_MSB:RO_LSB] == 2'b11);
    dbg_block = !debug &&
                (addr[ADDR_W-1:WIN_LSB_BITS] == DBG_WIN_BASE[ADDR_W-1:WIN_LSB_BITS]);
    ro_violation = wr_intent && ro_addr;
    illegal      = !hit || priv_low || ro_violation || dbg_block;
  end

  logic [WIN_TOPW-1:0] unused_top;
  assign unused_top = TRG_WIN_BASE[ADDR_W-1:WIN_LSB_BITS];

endmodule

// File: rtl/csr_alias_counter.sv
module csr_alias_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_en) begin
      count <= load_val;
    end else begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/csr_gate.sv
module csr_gate
  import csr_chk_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned XLEN   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        priv_mode,
  input  logic              debug_mode,
  input  logic              wr_intent,
  input  logic              acc_valid,
  input  logic [XLEN-1:0]   wr_data,
  output logic              illegal,
  output logic              ro_violation,
  output logic              hit,
  output logic [XLEN-1:0]   rd_data
);

  logic [XLEN-1:0] cnt_q;
  logic            cnt_sel;
  logic            cnt_load;

  csr_impl_lookup #(
    .ADDR_W (ADDR_W)
  ) u_lookup (
    .addr (csr_addr),
    .hit  (hit)
  );

  csr_rights_eval #(
    .ADDR_W (ADDR_W)
  ) u_rights (
    .addr         (csr_addr),
    .priv         (priv_mode),
    .debug        (debug_mode),
    .wr_intent    (wr_intent),
    .hit          (hit),
    .illegal      (illegal),
    .ro_violation (ro_violation)
  );

  always_comb begin
    cnt_sel  = !illegal &&
               ((csr_addr == CNT_URO_ADDR) || (csr_addr == CNT_MRW_ADDR));
    cnt_load = acc_valid && wr_intent && !illegal && (csr_addr == CNT_MRW_ADDR);
    rd_data  = cnt_sel ? cnt_q : '0;
  end

  csr_alias_counter #(
    .CNT_W (XLEN)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_en  (cnt_load),
    .load_val (wr_data),
    .count    (cnt_q)
  );

endmodule

// File: rtl/csr_gate_chk.sv
module csr_gate_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned XLEN   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [1:0]        priv_mode,
  input logic              debug_mode,
  input logic              wr_intent,
  input logic              acc_valid,
  input logic [XLEN-1:0]   wr_data,
  input logic              illegal,
  input logic              ro_violation,
  input logic              hit,
  input logic [XLEN-1:0]   cnt_q
);

  logic load_req;
  assign load_req = acc_valid && wr_intent && !illegal && (csr_addr == 12'hB00);

  assert_unimpl_traps_R1: assert property (@(posedge clk) disable iff (rst)
    !hit |-> illegal);

  assert_priv_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!debug_mode && (priv_mode < csr_addr[9:8])) |-> illegal);

  assert_ro_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_intent && (csr_addr[11:10] == 2'b11)) |-> (illegal && ro_violation));

  assert_dbg_window_R4: assert property (@(posedge clk) disable iff (rst)
    (!debug_mode && (csr_addr[11:4] == 8'h7B)) |-> illegal);

  assert_trig_open_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && (csr_addr[11:4] == 8'h7A) && (priv_mode == 2'b11)) |-> !illegal);

  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst)
    !load_req |=> (cnt_q == $past(cnt_q) + XLEN'(1)));

  assert_cnt_load_R10: assert property (@(posedge clk) disable iff (rst)
    load_req |=> (cnt_q == $past(wr_data)));

endmodule

bind csr_gate csr_gate_chk #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .csr_addr     (csr_addr),
  .priv_mode    (priv_mode),
  .debug_mode   (debug_mode),
  .wr_intent    (wr_intent),
  .acc_valid    (acc_valid),
  .wr_data      (wr_data),
  .illegal      (illegal),
  .ro_violation (ro_violation),
  .hit          (hit),
  .cnt_q        (cnt_q)
);

// File: tb/csr_gate_tb.sv
module csr_gate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csr_addr = '0;
  logic [1:0]  priv_mode = 2'b11;
  logic        debug_mode = 1'b0;
  logic        wr_intent = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        illegal, ro_violation, hit;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csr_gate u_dut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .priv_mode(priv_mode),
    .debug_mode(debug_mode), .wr_intent(wr_intent), .acc_valid(acc_valid),
    .wr_data(wr_data), .illegal(illegal), .ro_violation(ro_violation),
    .hit(hit), .rd_data(rd_data)
  );

  task automatic cmp(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [11:0] a, input logic [1:0] p, input logic d, input logic w);
    @(negedge clk);
    csr_addr = a; priv_mode = p; debug_mode = d; wr_intent = w; acc_valid = 1'b0;
    #2;
  endtask

  task automatic t_reset;
    drive(12'hC00, 2'b11, 1'b0, 1'b0);
    cmp("R8 counter zero in reset", rd_data, 32'd0);
  endtask

  task automatic t_unimpl;
    drive(12'h301, 2'b11, 1'b0, 1'b0);
    cmp("R1 hit 0x301", {31'd0, hit}, 32'd0);
    cmp("R1 illegal 0x301", {31'd0, illegal}, 32'd1);
    drive(12'h7C0, 2'b11, 1'b1, 1'b0);
    cmp("R1 illegal 0x7C0 debug", {31'd0, illegal}, 32'd1);
  endtask

  task automatic t_priv;
    drive(12'h300, 2'b01, 1'b0, 1'b1);
    cmp("R2 S write 0x300", {31'd0, illegal}, 32'd1);
    drive(12'h100, 2'b01, 1'b0, 1'b0);
    cmp("R2 S read 0x100", {31'd0, illegal}, 32'd0);
    drive(12'h100, 2'b00, 1'b0, 1'b0);
    cmp("R2 U read 0x100", {31'd0, illegal}, 32'd1);
    drive(12'h341, 2'b10, 1'b0, 1'b0);
    cmp("R2 H read 0x341", {31'd0, illegal}, 32'd1);
    drive(12'h800, 2'b00, 1'b0, 1'b1);
    cmp("R2 U write 0x800", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_ro;
    drive(12'hF11, 2'b11, 1'b0, 1'b1);
    cmp("R3 M write 0xF11 illegal", {31'd0, illegal}, 32'd1);
    cmp("R3 M write 0xF11 ro", {31'd0, ro_violation}, 32'd1);
    drive(12'hF11, 2'b11, 1'b0, 1'b0);
    cmp("R3 M read 0xF11 illegal", {31'd0, illegal}, 32'd0);
    cmp("R3 M read 0xF11 ro", {31'd0, ro_violation}, 32'd0);
    drive(12'hF11, 2'b00, 1'b0, 1'b1);
    cmp("R3 U write 0xF11 both", {30'd0, ro_violation, illegal}, 32'd3);
    drive(12'hC00, 2'b00, 1'b0, 1'b0);
    cmp("R3 U read 0xC00", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_debug;
    drive(12'h7B0, 2'b11, 1'b0, 1'b0);
    cmp("R4 M read 0x7B0", {31'd0, illegal}, 32'd1);
    drive(12'h7B1, 2'b11, 1'b1, 1'b1);
    cmp("R4 debug write 0x7B1", {31'd0, illegal}, 32'd0);
    drive(12'h300, 2'b00, 1'b1, 1'b1);
    cmp("R6 debug with U writes 0x300", {31'd0, illegal}, 32'd0);
    drive(12'h7B0, 2'b00, 1'b1, 1'b0);
    cmp("R6 debug with U reads 0x7B0", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_trigger;
    drive(12'h7A0, 2'b11, 1'b0, 1'b0);
    cmp("R5 M read 0x7A0", {31'd0, illegal}, 32'd0);
    drive(12'h7A1, 2'b11, 1'b0, 1'b1);
    cmp("R5 M write 0x7A1", {31'd0, illegal}, 32'd0);
    drive(12'h7A0, 2'b01, 1'b0, 1'b0);
    cmp("R2 S read 0x7A0", {31'd0, illegal}, 32'd1);
  endtask

  task automatic t_clean;
    drive(12'h305, 2'b11, 1'b0, 1'b1);
    cmp("R7 legal write flags", {29'd0, hit, ro_violation, illegal}, 32'd4);
    cmp("R12 rd_data off counter", rd_data, 32'd0);
    drive(12'hB00, 2'b00, 1'b0, 1'b0);
    cmp("R12 rd_data on illegal 0xB00", rd_data, 32'd0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    drive(12'hC00, 2'b00, 1'b0, 1'b0);
    v = rd_data;
    @(posedge clk); #2;
    cmp("R8 count step", rd_data, v + 32'd1);
    csr_addr = 12'hB00; priv_mode = 2'b11; #1;
    cmp("R9 alias same value", rd_data, v + 32'd1);
  endtask

  task automatic t_write;
    drive(12'hB00, 2'b11, 1'b0, 1'b1);
    acc_valid = 1'b1; wr_data = 32'h1234_5678;
    @(posedge clk); #2;
    acc_valid = 1'b0; wr_intent = 1'b0; #1;
    cmp("R10 load wins over increment", rd_data, 32'h1234_5678);
    @(posedge clk); #2;
    cmp("R10 count resumes", rd_data, 32'h1234_5679);
  endtask

  task automatic t_blocked;
    logic [31:0] v;
    drive(12'hC00, 2'b00, 1'b0, 1'b0);
    v = rd_data;
    wr_intent = 1'b1; acc_valid = 1'b1; wr_data = 32'hDEAD_0000;
    @(posedge clk); #2;
    acc_valid = 1'b0; wr_intent = 1'b0; #1;
    cmp("R11 write to 0xC00 blocked", rd_data, v + 32'd1);
    v = rd_data;
    csr_addr = 12'hB00; priv_mode = 2'b01; wr_intent = 1'b1; acc_valid = 1'b1;
    @(posedge clk); #2;
    acc_valid = 1'b0; wr_intent = 1'b0; priv_mode = 2'b11; #1;
    cmp("R11 S write 0xB00 blocked", rd_data, v + 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_unimpl();
    t_priv();
    t_ro();
    t_debug();
    t_trigger();
    t_clean();
    @(negedge clk); rst = 1'b0;
    t_count();
    t_write();
    t_blocked();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule